// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive by deciding when a refresh must take place. The device needs every one of its 2048 rows refreshed within a 32 ms retention window. The scheduler divides the system clock down to one tick per row interval. Each tick adds one refresh to an owed count. While anything is owed and no refresh is running, the block raises a request to the access sequencer. The sequencer accepts the request with a grant and reports the end of the refresh with a done pulse.

Two refresh styles are available, chosen by a mode input. In CAS-before-RAS style the device keeps its own row count, so no address is needed. In RAS-only style the scheduler supplies an 11-bit row address from its own counter. The counter advances after each completed RAS-only refresh.

Refreshes can be postponed while the sequencer serves accesses. The owed count saturates at a configurable depth. When it reaches that depth, an urgent flag tells the sequencer to serve refresh before any new access.

Top module: `refsch_top`

## Requirements
- R1: An interval tick occurs every INTERVAL = floor(CLK_HZ × 32 ms / 2048) clock cycles. The first tick lands on the INTERVAL-th rising edge after reset is released, so the request is first seen high after that edge.
- R2: While reset is asserted (rst_n low), ref_req_o and ref_urgent_o are 0 and ref_row_o is 0. The owed count and the in-progress state are cleared.
- R3: The owed count rises by one on each tick and falls by one on each accepted grant. When a tick and an accepted grant fall in the same cycle, the count is left unchanged.
- R4: ref_req_o is 1 exactly when the owed count is nonzero and no refresh is in progress.
- R5: A grant (ref_gnt_i = 1) while ref_req_o is 0 is ignored. It neither changes the owed count nor starts a refresh.
- R6: A refresh is in progress from the cycle after an accepted grant until the cycle after ref_done_i = 1. A done pulse while no refresh is in progress is ignored.
- R7: ref_urgent_o is 1 exactly when the owed count equals MAX_DEBT (default 8).
- R8: The owed count never exceeds MAX_DEBT. A tick that arrives at MAX_DEBT with no accepted grant in the same cycle is dropped.
- R9: When a refresh completes in RAS-only style (ref_cbr_o = 0), ref_row_o advances by one and wraps from 2047 to 0. A completed CAS-before-RAS refresh (ref_cbr_o = 1) leaves ref_row_o unchanged.
- R10: While no refresh is in progress, ref_cbr_o follows mode_cbr_i (1 = CAS-before-RAS, 0 = RAS-only). During a refresh it holds the value mode_cbr_i had at the accepted grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cbr_i | input | 1 | Refresh style select: 1 = CAS-before-RAS, 0 = RAS-only |
| ref_gnt_i | input | 1 | Sequencer accepts the pending refresh |
| ref_done_i | input | 1 | Sequencer reports that the running refresh has finished |
| ref_req_o | output | 1 | A refresh is owed and may be started |
| ref_urgent_o | output | 1 | Owed count is at its limit; serve refresh before new accesses |
| ref_cbr_o | output | 1 | Style of the current or next refresh |
| ref_row_o | output | ROW_W (11) | Row address for a RAS-only refresh |

## Verification
The interval tick and an accepted grant can land on the same clock edge. This matters most when the owed count is already at its limit, because a wrong order of add, subtract and clamp shows up there. The bench uses its own model of the interval counter to find the cycle just before a tick. It drives the grant into that cycle with the count saturated. After the refresh completes, it judges the result by ref_urgent_o staying high: the net change must be zero, not a drop by one. A second collision, a mode change during a running refresh, is provoked the same way and judged on ref_cbr_o and ref_row_o.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic {
    KIND_RAS_ONLY = 1'b0,
    KIND_CBR      = 1'b1
  } ref_kind_e;

  // Whole clock cycles between row refreshes, rounded down.
  function automatic int unsigned interval_cycles(
    input longint unsigned clk_hz,
    input longint unsigned window_ns,
    input longint unsigned rows
  );
    longint unsigned num;
    num = clk_hz * window_ns;
    return int'(num / (64'd1_000_000_000 * rows));
  endfunction

  // Owed count after one cycle: add tick, remove grant, clamp at the limit.
  function automatic int unsigned debt_after(
    input int unsigned debt,
    input logic        tick,
    input logic        take,
    input int unsigned limit
  );
    int unsigned n;
    n = debt + (tick ? 1 : 0);
    if (take) n = n - 1;
    if (n > limit) n = limit;
    return n;
  endfunction

endpackage

// File: rtl/refsch_timer.sv
module refsch_timer #(
  parameter int unsigned INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW       = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [DW-1:0] debt_o,
  output logic          owed_o,
  output logic          full_o
);
  logic [DW-1:0] debt_q;

  assign debt_o = debt_q;
  assign owed_o = (debt_q != '0);
  assign full_o = (debt_q == DW'(MAX_DEBT));

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= DW'(refsch_pkg::debt_after(int'(debt_q), tick_i, take_i, MAX_DEBT));
  end
endmodule

// File: rtl/refsch_ctl.sv
module refsch_ctl
  import refsch_pkg::*;
#(
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cbr_i,
  input  logic             take_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             finish_o,
  output ref_kind_e        kind_o,
  output logic [ROW_W-1:0] row_o
);
  logic             busy_q;
  ref_kind_e        kind_q;
  logic [ROW_W-1:0] row_q;

  assign busy_o   = busy_q;
  assign finish_o = busy_q && done_i;
  assign kind_o   = busy_q ? kind_q : ref_kind_e'(mode_cbr_i);
  assign row_o    = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= KIND_RAS_ONLY;
      row_q  <= '0;
    end else if (take_i) begin
      busy_q <= 1'b1;
      kind_q <= ref_kind_e'(mode_cbr_i);
    end else if (finish_o) begin
      busy_q <= 1'b0;
      if (kind_q == KIND_RAS_ONLY) row_q <= row_q + 1'b1;
    end
  end
endmodule

// File: rtl/refsch_top.sv
module refsch_top
  import refsch_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter longint unsigned WINDOW_NS = 32_000_000,
  parameter int unsigned     ROW_W     = 11,
  parameter int unsigned     MAX_DEBT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cbr_i,
  input  logic             ref_gnt_i,
  input  logic             ref_done_i,
  output logic             ref_req_o,
  output logic             ref_urgent_o,
  output logic             ref_cbr_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam longint unsigned ROWS     = 64'd1 << ROW_W;
  localparam int unsigned     INTERVAL = interval_cycles(CLK_HZ, WINDOW_NS, ROWS);
  localparam int unsigned     DW       = $clog2(MAX_DEBT + 1);

  // Named internal events
  logic          tick;
  logic          take;
  logic          finish;
  logic          busy;
  logic          owed;
  logic          full;
  logic [DW-1:0] debt;
  ref_kind_e     kind;

  assign ref_req_o    = owed && !busy;
  assign take         = ref_req_o && ref_gnt_i;
  assign ref_urgent_o = full;
  assign ref_cbr_o    = (kind == KIND_CBR);

  refsch_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  refsch_debt #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .take_i (take),
    .debt_o (debt),
    .owed_o (owed),
    .full_o (full)
  );

  refsch_ctl #(.ROW_W(ROW_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_cbr_i (mode_cbr_i),
    .take_i     (take),
    .done_i     (ref_done_i),
    .busy_o     (busy),
    .finish_o   (finish),
    .kind_o     (kind),
    .row_o      (ref_row_o)
  );
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             take,
  input logic             finish,
  input logic             busy,
  input logic [DW-1:0]    debt,
  input logic             cbr,
  input logic [ROW_W-1:0] row,
  input logic             req,
  input logic             urgent,
  input logic             gnt,
  input logic             done
);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);

  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r3_debt_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && debt != LIMIT) |=> debt == DW'($past(debt) + 1'b1));

  a_r3_debt_down: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick) |=> debt == DW'($past(debt) - 1'b1));

  a_r3_debt_even: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && take) |=> $stable(debt));

  a_r4_req_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (debt != '0) && !busy);

  a_r5_gnt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !req && !tick) |=> $stable(debt));

  a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r7_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !busy) |-> req);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= LIMIT);

  a_r9_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cbr) |=> row == ROW_W'($past(row) + 1'b1));

  a_r9_row_cbr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cbr) |=> $stable(row));

  a_r10_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(cbr));
endmodule

bind refsch_top refsch_chk #(.ROW_W(ROW_W), .MAX_DEBT(MAX_DEBT), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .take   (take),
  .finish (finish),
  .busy   (busy),
  .debt   (debt),
  .cbr    (ref_cbr_o),
  .row    (ref_row_o),
  .req    (ref_req_o),
  .urgent (ref_urgent_o),
  .gnt    (ref_gnt_i),
  .done   (ref_done_i)
);

// File: tb/tb_refsch_top.sv
`timescale 1ns/1ps
module tb_refsch_top;
  localparam longint unsigned TB_CLK_HZ = 2_000_000;
  localparam int ROW_W   = 11;
  localparam int NROWS   = 2048;
  localparam int MAXD    = 8;
  localparam int WIN_CYC = int'(TB_CLK_HZ / 1000) * 32;   // cycles in 32 ms
  localparam int EXP_INT = WIN_CYC / NROWS;               // 31 at 2 MHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic m_gnt = 1'b0, m_done = 1'b0;
  logic a_gnt = 1'b0, a_done = 1'b0;
  logic auto_en = 1'b0;
  logic cmp_en = 1'b0;
  wire  gnt  = auto_en ? a_gnt  : m_gnt;
  wire  done = auto_en ? a_done : m_done;

  logic             ref_req, ref_urgent, ref_cbr;
  logic [ROW_W-1:0] ref_row;

  refsch_top #(.CLK_HZ(TB_CLK_HZ), .ROW_W(ROW_W), .MAX_DEBT(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .mode_cbr_i(mode), .ref_gnt_i(gnt), .ref_done_i(done),
    .ref_req_o(ref_req), .ref_urgent_o(ref_urgent), .ref_cbr_o(ref_cbr), .ref_row_o(ref_row)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  // reference model state
  int m_tcnt = 0, m_debt = 0, m_row = 0;
  bit m_busy = 0, m_kind = 0;
  int prev_row = 0;
  bit seen_wrap = 0;
  int a_wait = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcnt = 0; m_debt = 0; m_row = 0; m_busy = 0; m_kind = 0;
    end else begin
      bit t, acc;
      t   = (m_tcnt == EXP_INT - 1);
      acc = (m_debt != 0) && !m_busy && gnt;
      m_tcnt = t ? 0 : m_tcnt + 1;
      m_debt = m_debt + (t ? 1 : 0) - (acc ? 1 : 0);
      if (m_debt > MAXD) m_debt = MAXD;
      if (acc) begin
        m_busy = 1; m_kind = mode;
      end else if (m_busy && done) begin
        m_busy = 0;
        if (!m_kind) m_row = (m_row + 1) % NROWS;
      end
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_en) begin
      chk(ref_req == ((m_debt != 0) && !m_busy), "R4 request", ref_req, (m_debt != 0) && !m_busy);
      chk(ref_urgent == (m_debt == MAXD), "R7 urgent", ref_urgent, m_debt == MAXD);
      chk(int'(ref_row) == m_row, "R9 row", ref_row, m_row);
      chk(ref_cbr == (m_busy ? m_kind : mode), "R10 style", ref_cbr, m_busy ? m_kind : mode);
      if (prev_row == NROWS - 1 && ref_row == 0) seen_wrap = 1;
      prev_row = ref_row;
    end
  end

  // automatic sequencer: grant, one busy cycle, done
  always @(negedge clk) begin
    if (a_done) a_done = 0;
    if (a_gnt) begin
      a_gnt = 0; a_wait = 1;
    end else if (a_wait > 0) begin
      a_wait--;
      if (a_wait == 0) a_done = 1;
    end else if (auto_en && ref_req && !a_done) begin
      a_gnt = 1;
    end
  end

  task automatic refresh_once();
    m_gnt = 1; @(negedge clk); m_gnt = 0;
    @(negedge clk); m_done = 1; @(negedge clk); m_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(ref_req == 0, "R2 reset request", ref_req, 0);
    chk(ref_urgent == 0, "R2 reset urgent", ref_urgent, 0);
    chk(ref_row == 0, "R2 reset row", ref_row, 0);
    rst_n = 1; cmp_en = 1;

    // R5 / R6: stray grant and done before anything is owed; R1 first tick
    n = 0;
    forever begin
      @(negedge clk); n++;
      #1;
      if (ref_req) break;
      if (n == 3) begin m_gnt = 1; m_done = 1; end
      if (n == 4) begin m_gnt = 0; m_done = 0; end
      if (n == 6) chk(ref_req == 0, "R5 stray grant ignored", ref_req, 0);
    end
    chk(n == EXP_INT, "R1 first interval", n, EXP_INT);

    // R7 / R8: let the debt reach the limit and stay there
    while (!ref_urgent) @(negedge clk);
    #1;
    chk(ref_req == 1, "R7 urgent with request", ref_req, 1);
    repeat (2 * EXP_INT) @(negedge clk);
    #1;
    chk(ref_urgent == 1, "R8 held at limit", ref_urgent, 1);

    // R3: tick and grant on the same edge at the limit
    while (m_tcnt != EXP_INT - 1) @(negedge clk);
    refresh_once();
    #1;
    chk(ref_urgent == 1, "R3 tick and grant cancel", ref_urgent, 1);

    // R8: a grant without a tick drops below the limit at once
    while (m_tcnt != 2) @(negedge clk);
    refresh_once();
    #1;
    chk(ref_urgent == 0, "R8 one below limit", ref_urgent, 0);
    chk(ref_req == 1, "R4 still owed", ref_req, 1);

    // R10 / R9: CBR refresh with a mode change while running
    while (m_tcnt < 2 || m_tcnt > EXP_INT - 8) @(negedge clk);
    mode = 1; #1;
    chk(ref_cbr == 1, "R10 follows input when idle", ref_cbr, 1);
    n = int'(ref_row);
    m_gnt = 1; @(negedge clk); m_gnt = 0;
    mode = 0; #1;
    chk(ref_cbr == 1, "R10 held during refresh", ref_cbr, 1);
    @(negedge clk); m_done = 1; @(negedge clk); m_done = 0; #1;
    chk(int'(ref_row) == n, "R9 CBR keeps row", ref_row, n);
    chk(ref_cbr == 0, "R10 follows input again", ref_cbr, 0);

    // R9: RAS-only refresh advances the row
    refresh_once(); #1;
    chk(int'(ref_row) == n + 1, "R9 RAS-only advances row", ref_row, n + 1);

    // R9: run until the row counter wraps
    auto_en = 1;
    n = 0;
    while (!seen_wrap && n < 2100 * EXP_INT) begin @(negedge clk); n++; end
    chk(seen_wrap, "R9 row wraps to zero", seen_wrap, 1);
    repeat (4 * EXP_INT) @(negedge clk);
    #1;
    chk(ref_urgent == 0, "R7 drained", ref_urgent, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule